// File: doc/BRIEF.md
# Multi-mode 32-bit timer

This block is a general-purpose 32-bit counter behind a small write-only register port. One counter serves five behaviours: a one-shot down-count, a periodic down-count that reloads itself, a free-running up-count that wraps, an up-count of edges on an event pin, and a watchdog. The watchdog is held off by software kicks. While the counter runs, a comparator turns the count into a PWM waveform. The period comes from the reload or wrap length, and the duty comes from a compare register.

The count step comes from one of three places: every bus clock cycle, a rising edge on an external clock pin, or a rising edge on the terminal-count pulse of a neighbouring timer. Both pins and the event pin are resynchronised with two flops and edge-detected. They therefore act only as count enables in the bus clock domain. Each terminal count drives a one-cycle cascade pulse, so timers can be chained for long periods.

Top module: `mm_timer32`

## Requirements
- R1: After reset, `count` is 0 and `irq`, `pwm`, `wdog_rst` and `casc_out` are all low.
- R2: Mode code 0 (one-shot) counts down by one per tick. On the tick that takes the count from 1 (or from 0) it leaves 0, sets `irq` and `casc_out` high for one cycle and stops running, so the count stays 0.
- R3: Mode code 1 (periodic) counts down by one per tick. On the tick at 1 it reloads the load value and pulses `irq` and `casc_out`, so with load L the pulse repeats every L ticks.
- R4: Mode code 2 (free-running) counts up by one per tick from the value present at enable. It wraps from 0xFFFFFFFF to 0, which pulses `irq` and `casc_out`. It never reloads.
- R5: Mode code 3 (event) adds one for each rising edge of `evt_in`, seen through a two-flop synchroniser. A level held high counts only once, and the source select has no effect.
- R6: The source field chooses the tick. Code 0 is every bus cycle, code 1 is each synchronised rising edge of `ext_clk`, code 2 is each synchronised rising edge of `casc_in`, and code 3 never ticks.
- R7: `pwm` is high exactly when the timer is running and `count` is below the compare value.
- R8: Mode code 4 (watchdog) counts down like R2. On expiry with the reset-select bit set, `wdog_rst` rises and stays high until the next control write. With the bit clear, expiry gives a one-cycle `irq` pulse and `wdog_rst` stays low.
- R9: A write to offset 3 (kick) reloads the load value while running in watchdog mode. In any other mode it has no effect on the count.
- R10: The register offsets are 0 control, 1 load, 2 compare and 3 kick. The control fields are mode in bits 2:0, source in 4:3, enable in bit 5 and watchdog reset-select in bit 6. Writing enable=1 while stopped loads the count with the load value and starts the timer. Writing enable=0 stops it, after which the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register offset |
| wr_data | input | 32 | Write data |
| ext_clk | input | 1 | External count clock pin |
| casc_in | input | 1 | Terminal-count pulse from a neighbouring timer |
| evt_in | input | 1 | Event input for event mode |
| count | output | 32 | Current counter value |
| irq | output | 1 | One-cycle interrupt pulse |
| pwm | output | 1 | PWM waveform |
| wdog_rst | output | 1 | Watchdog reset request (level) |
| casc_out | output | 1 | One-cycle terminal-count pulse |

## Verification
The in-design properties watch the step-by-one down-count, the halt after one-shot expiry, the periodic reload, the wrap in free-running mode, the frozen count while stopped and the stickiness of the watchdog reset request on every clock. Only the bench scenarios can show the end-to-end timing: the latency through the synchronisers on the external, cascade and event pins, and that a held event level counts once. They also show that kicks postpone expiry and are ignored outside watchdog mode, and that the PWM level follows the compare value across modes.

// File: rtl/mt_pkg.sv
package mt_pkg;
    typedef enum logic [2:0] {
        M_SINGLE = 3'd0,
        M_AUTO   = 3'd1,
        M_FREE   = 3'd2,
        M_EVENT  = 3'd3,
        M_WDOG   = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        S_INT  = 2'd0,
        S_EXT  = 2'd1,
        S_CASC = 2'd2,
        S_NONE = 2'd3
    } src_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_LOAD = 2'd1;
    localparam logic [1:0] A_CMP  = 2'd2;
    localparam logic [1:0] A_KICK = 2'd3;

    localparam int F_SRC_LO = 3;
    localparam int F_EN     = 5;
    localparam int F_WDSEL  = 6;
endpackage

// File: rtl/mt_edge_sync.sv
module mt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/mt_core.sv
module mt_core
    import mt_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             src_tick,
    input  logic             evt_tick,
    output src_e             src_sel,
    output logic [WIDTH-1:0] cnt,
    output logic [WIDTH-1:0] cmp,
    output logic             running,
    output logic             irq,
    output logic             casc,
    output logic             wdrst
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
    localparam logic [WIDTH-1:0] MAX = {WIDTH{1'b1}};

    typedef struct packed {
        mode_e            mode;
        src_e             src;
        logic             wdsel;
        logic [WIDTH-1:0] load;
        logic [WIDTH-1:0] cmp;
        logic [WIDTH-1:0] cnt;
        logic             run;
        logic             irq;
        logic             casc;
        logic             wdrst;
    } st_t;

    st_t d, q;
    logic tick, expire;

    always_comb begin
        tick   = (q.mode == M_EVENT) ? evt_tick : src_tick;
        expire = 1'b0;
        d      = q;
        d.irq  = 1'b0;
        d.casc = 1'b0;

        if (q.run && tick) begin
            unique case (q.mode)
                M_SINGLE, M_WDOG: begin
                    if (q.cnt <= ONE) begin
                        d.cnt  = '0;
                        d.run  = 1'b0;
                        expire = 1'b1;
                    end else begin
                        d.cnt = q.cnt - ONE;
                    end
                end
                M_AUTO: begin
                    if (q.cnt <= ONE) begin
                        d.cnt  = q.load;
                        expire = 1'b1;
                    end else begin
                        d.cnt = q.cnt - ONE;
                    end
                end
                M_FREE, M_EVENT: begin
                    d.cnt  = q.cnt + ONE;
                    expire = (q.cnt == MAX);
                end
                default: ;
            endcase
        end

        if (expire) begin
            d.casc = 1'b1;
            if (q.mode == M_WDOG && q.wdsel) d.wdrst = 1'b1;
            else                             d.irq   = 1'b1;
        end

        if (wr_en) begin
            unique case (wr_addr)
                A_CTRL: begin
                    d.mode  = mode_e'(wr_data[2:0]);
                    d.src   = src_e'(wr_data[F_SRC_LO+1:F_SRC_LO]);
                    d.wdsel = wr_data[F_WDSEL];
                    d.wdrst = 1'b0;
                    if (wr_data[F_EN]) begin
                        if (!q.run) begin
                            d.cnt = q.load;
                            d.run = 1'b1;
                        end
                    end else begin
                        d.run = 1'b0;
                    end
                end
                A_LOAD: d.load = wr_data;
                A_CMP:  d.cmp  = wr_data;
                A_KICK: begin
                    if (q.run && q.mode == M_WDOG) d.cnt = q.load;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{mode: M_SINGLE, src: S_INT, default: '0};
        end else begin
            q <= d;
        end
    end

    assign src_sel = q.src;
    assign cnt     = q.cnt;
    assign cmp     = q.cmp;
    assign running = q.run;
    assign irq     = q.irq;
    assign casc    = q.casc;
    assign wdrst   = q.wdrst;

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && q.mode == M_SINGLE && tick && q.cnt > ONE && !wr_en)
        |=> (q.cnt == $past(q.cnt) - ONE)); // R2
    AST_SINGLE_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && q.mode == M_SINGLE && tick && q.cnt <= ONE && !wr_en)
        |=> (!q.run && q.cnt == '0 && irq)); // R2
    AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && q.mode == M_AUTO && tick && q.cnt <= ONE && !wr_en)
        |=> (q.cnt == $past(q.load) && irq)); // R3
    AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && q.mode == M_FREE && tick && q.cnt == MAX && !wr_en)
        |=> (q.cnt == '0 && casc)); // R4
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.run && !(wr_en && wr_addr == A_CTRL))
        |=> $stable(q.cnt)); // R10
    AST_WDOG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wdrst && !(wr_en && wr_addr == A_CTRL))
        |=> q.wdrst); // R8
endmodule

// File: rtl/mt_pwm.sv
module mt_pwm #(
    parameter int WIDTH = 32
) (
    input  logic             running,
    input  logic [WIDTH-1:0] cnt,
    input  logic [WIDTH-1:0] cmp,
    output logic             pwm
);
    assign pwm = running && (cnt < cmp);
endmodule

// File: rtl/mm_timer32.sv
module mm_timer32
    import mt_pkg::*;
#(
    parameter int WIDTH       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             ext_clk,
    input  logic             casc_in,
    input  logic             evt_in,
    output logic [WIDTH-1:0] count,
    output logic             irq,
    output logic             pwm,
    output logic             wdog_rst,
    output logic             casc_out
);
    localparam int N_PINS = 3;

    logic [N_PINS-1:0] pin_raw, pin_rise;
    logic              src_tick, running;
    logic [WIDTH-1:0]  cmp;
    src_e              src_sel;

    assign pin_raw = {evt_in, casc_in, ext_clk};

    genvar g;
    generate
        for (g = 0; g < N_PINS; g++) begin : g_sync
            mt_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (pin_raw[g]),
                .rise (pin_rise[g])
            );
        end
    endgenerate

    always_comb begin
        unique case (src_sel)
            S_INT:   src_tick = 1'b1;
            S_EXT:   src_tick = pin_rise[0];
            S_CASC:  src_tick = pin_rise[1];
            default: src_tick = 1'b0;
        endcase
    end

    mt_core #(.WIDTH(WIDTH)) i_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .src_tick(src_tick),
        .evt_tick(pin_rise[2]),
        .src_sel (src_sel),
        .cnt     (count),
        .cmp     (cmp),
        .running (running),
        .irq     (irq),
        .casc    (casc_out),
        .wdrst   (wdog_rst)
    );

    mt_pwm #(.WIDTH(WIDTH)) i_pwm (
        .running(running),
        .cnt    (count),
        .cmp    (cmp),
        .pwm    (pwm)
    );

    AST_PWM_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CTRL && !wr_data[F_EN]) |=> !pwm); // R7
endmodule

// File: tb/test_mm_timer32.sv
module test_mm_timer32;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        ext_clk = 1'b0, casc_in = 1'b0, evt_in = 1'b0;
    logic [31:0] count;
    logic        irq, pwm, wdog_rst, casc_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    mm_timer32 i_mm_timer32 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ext_clk(ext_clk), .casc_in(casc_in),
        .evt_in(evt_in), .count(count), .irq(irq), .pwm(pwm),
        .wdog_rst(wdog_rst), .casc_out(casc_out)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [2:0]  mode;
        logic [31:0] load;
        logic [31:0] cmp;
        logic [15:0] k;
        logic [31:0] exp_cnt;
        logic        exp_pwm;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'd2, 3'd0, 32'd10,         32'd5,   16'd3,  32'd7,   1'b0},
        '{8'd2, 3'd0, 32'd10,         32'd5,   16'd7,  32'd3,   1'b1},
        '{8'd2, 3'd0, 32'd4,          32'd5,   16'd10, 32'd0,   1'b0},
        '{8'd3, 3'd1, 32'd4,          32'd4,   16'd5,  32'd3,   1'b1},
        '{8'd3, 3'd1, 32'd4,          32'd4,   16'd4,  32'd4,   1'b0},
        '{8'd4, 3'd2, 32'd100,        32'd200, 16'd20, 32'd120, 1'b1},
        '{8'd4, 3'd2, 32'hFFFF_FFFE,  32'd0,   16'd3,  32'd1,   1'b0},
        '{8'd5, 3'd3, 32'd7,          32'd8,   16'd5,  32'd7,   1'b1}
    };

    function automatic logic [31:0] ctrl(input logic [2:0] m, input logic [1:0] s,
                                         input logic e, input logic w);
        return {25'd0, w, e, s, m};
    endfunction

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic setup(input logic [2:0] m, input logic [1:0] s, input logic w,
                         input logic [31:0] ld, input logic [31:0] cp);
        wr(2'd0, ctrl(m, s, 1'b0, w));
        wr(2'd1, ld);
        wr(2'd2, cp);
        wr(2'd0, ctrl(m, s, 1'b1, w));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 count", count, 32'd0);
        chk("R1 outputs", {28'd0, irq, pwm, wdog_rst, casc_out}, 32'd0);

        // table walk (R2 R3 R4 R5 R7)
        foreach (VECS[i]) begin
            setup(VECS[i].mode, 2'd0, 1'b0, VECS[i].load, VECS[i].cmp);
            step(int'(VECS[i].k));
            chk($sformatf("R%0d vec%0d count", VECS[i].req, i), count, VECS[i].exp_cnt);
            chk($sformatf("R7 vec%0d pwm", i), {31'd0, pwm}, {31'd0, VECS[i].exp_pwm});
        end

        // R2 one-shot expiry pulse and halt
        setup(3'd0, 2'd0, 1'b0, 32'd3, 32'd0);
        step(2);
        chk("R2 before expiry irq", {31'd0, irq}, 32'd0);
        step(1);
        chk("R2 expiry irq+casc", {30'd0, irq, casc_out}, 32'd3);
        step(5);
        chk("R2 halted count", count, 32'd0);
        chk("R2 single pulse", {31'd0, irq}, 32'd0);

        // R3 periodic pulses
        setup(3'd1, 2'd0, 1'b0, 32'd3, 32'd0);
        step(3);
        chk("R3 first period", {irq, count[30:0]}, {1'b1, 31'd3});
        step(3);
        chk("R3 second period", {irq, count[30:0]}, {1'b1, 31'd3});

        // R4 wrap pulse
        setup(3'd2, 2'd0, 1'b0, 32'hFFFF_FFFF, 32'd0);
        step(1);
        chk("R4 wrap count", count, 32'd0);
        chk("R4 wrap irq+casc", {30'd0, irq, casc_out}, 32'd3);

        // R10 disable freezes count
        wr(2'd0, ctrl(3'd2, 2'd0, 1'b0, 1'b0));
        held = count;
        step(5);
        chk("R10 frozen", count, held);

        // R5 event edges, held level counts once
        setup(3'd3, 2'd0, 1'b0, 32'd0, 32'd0);
        evt_in = 1'b1; step(4); evt_in = 1'b0; step(4);
        chk("R5 one edge", count, 32'd1);
        evt_in = 1'b1; step(2); evt_in = 1'b0; step(4);
        chk("R5 two edges", count, 32'd2);

        // R6 external source
        setup(3'd2, 2'd1, 1'b0, 32'd0, 32'd0);
        for (int j = 0; j < 3; j++) begin
            ext_clk = 1'b1; step(2); ext_clk = 1'b0; step(2);
        end
        step(3);
        chk("R6 ext edges", count, 32'd3);
        // R6 cascade source
        setup(3'd2, 2'd2, 1'b0, 32'd0, 32'd0);
        for (int j = 0; j < 2; j++) begin
            casc_in = 1'b1; step(1); casc_in = 1'b0; step(3);
        end
        step(3);
        chk("R6 cascade edges", count, 32'd2);
        // R6 code 3 never ticks
        setup(3'd2, 2'd3, 1'b0, 32'd9, 32'd0);
        step(10);
        chk("R6 no-source", count, 32'd9);

        // R9 kick postpones watchdog, R8 reset request
        setup(3'd4, 2'd0, 1'b1, 32'd5, 32'd0);
        step(3);
        wr(2'd3, 32'd0);
        chk("R9 kick reload", count, 32'd5);
        step(3);
        chk("R9 after kick", count, 32'd2);
        step(2);
        chk("R8 reset request", {31'd0, wdog_rst}, 32'd1);
        chk("R8 no irq with reset", {31'd0, irq}, 32'd0);
        step(10);
        chk("R8 reset held", {31'd0, wdog_rst}, 32'd1);
        wr(2'd0, ctrl(3'd4, 2'd0, 1'b0, 1'b1));
        chk("R8 reset cleared", {31'd0, wdog_rst}, 32'd0);

        // R8 interrupt selection
        setup(3'd4, 2'd0, 1'b0, 32'd2, 32'd0);
        step(2);
        chk("R8 irq select", {30'd0, irq, wdog_rst}, 32'd2);

        // R9 kick ignored outside watchdog
        setup(3'd2, 2'd0, 1'b0, 32'd50, 32'd0);
        step(2);
        chk("R9 free before kick", count, 32'd52);
        wr(2'd3, 32'd0);
        chk("R9 kick ignored", count, 32'd53);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule